// File: doc/BRIEF.md
# Bit-Masked Control Register Bank

This block holds a small set of 32-bit control registers on a plain memory-mapped bus. Every write word carries its own per-bit enable mask: the upper half of the word selects which bits of the lower half are written. Software can therefore set or clear single control bits without first reading the register back, and two agents that own different bits of one register never overwrite each other's fields.

The lower 16 bits of each control register drive a parallel output bus that feeds the circuits under control. The bank also has one read-only status word. It reports a calibration-complete input and a delay-line-locked input. The whole bank sits at a parameterised base address inside a larger register space. Any access completes with a registered ready pulse one cycle later.

Top module: `wmask_ctrl_bank`

## Requirements
- R1: A synchronous active-high reset clears every control register to zero and drives `bus_ready` and `bus_rdata` to zero.
- R2: On a write to a control register, bit x (0..15) takes `bus_wdata[x]` only when `bus_wdata[x+16]` is 1. Otherwise it keeps its value. For example, 0x0010_0010 sets bit 4 alone.
- R3: Control register i (0..NUM_CTRL-1) is at byte address BASE_ADDR + 4*i, which is 0xF780 to 0xF798 by default. A write changes only the addressed register.
- R4: The status word at BASE_ADDR + 0x20 is read-only. On a read, bit 6 is `cal_done_i`, bit 5 is `dll_ready_i` and every other bit is zero, all sampled at the access edge. A write to it changes no control output.
- R5: A read of a control register returns its stored 16 bits in `bus_rdata[15:0]`, with `bus_rdata[31:16]` zero.
- R6: Addresses outside the map return zero on a read and change nothing on a write. This covers misaligned addresses, offset 0x1C, offset 0x24 and addresses below the base.
- R7: `bus_ready` is high for exactly the one cycle after each clock edge at which `bus_wr` or `bus_rd` is sampled high, and `bus_rdata` is valid in that cycle. `bus_ready` is never high without an access.
- R8: `ctrl_out[16*i +: 16]` always equals control register i. It shows a new value from the clock edge at which the write is sampled.
- R9: A write whose mask half is all zeros leaves the addressed register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (16) | Byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write word: mask in [31:16], values in [15:0] |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Registered read data |
| bus_ready | output | 1 | One-cycle completion pulse |
| cal_done_i | input | 1 | Calibration complete status input |
| dll_ready_i | input | 1 | Delay line locked status input |
| ctrl_out | output | NUM_CTRL*16 (112) | Concatenated control register values, register 0 in the low bits |

## Verification
The hardest case to reach is a write where mask and value disagree bit by bit, so that some bits are set, others are cleared and the rest must hold. Reaching it needs a register that already contains a mixed pattern. The stimulus first loads a known pattern with a full mask. It then applies partial masks whose value bits are chosen to be opposite to some held bits and equal to others, so an inverted or shifted mask shows up as a wrong bit. Back-to-back reads with no idle cycle between them, and reads of the status word while its inputs change, confirm that each ready pulse carries the data of its own access.

// File: rtl/wmask_pkg.sv
package wmask_pkg;
  localparam int WORD_W = 32;
  localparam int HALF_W = WORD_W / 2;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_CTRL = 2'd1,
    SEL_STAT = 2'd2
  } sel_e;
endpackage

// File: rtl/wmask_decode.sv
module wmask_decode
  import wmask_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 16'hF780,
  parameter int NUM_CTRL  = 7,
  parameter int STAT_OFS  = 8'h20,
  parameter int IDX_W     = 3
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [IDX_W-1:0]  idx
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE_ADDR);
  localparam logic [ADDR_W-1:0] SPAN_V = ADDR_W'(NUM_CTRL * 4);
  localparam logic [ADDR_W-1:0] STAT_V = ADDR_W'(STAT_OFS);

  logic [ADDR_W-1:0] offset;

  always_comb begin
    offset = addr - BASE_V;
    idx    = offset[IDX_W+1:2];
    if (offset[1:0] == 2'b00 && offset < SPAN_V)
      sel = SEL_CTRL;
    else if (offset == STAT_V)
      sel = SEL_STAT;
    else
      sel = SEL_NONE;
  end
endmodule

// File: rtl/wmask_field.sv
module wmask_field #(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [2*HALF_W-1:0] wr_word,
  output logic [HALF_W-1:0]   q
);
  logic [HALF_W-1:0] mask;
  logic [HALF_W-1:0] val;

  assign mask = wr_word[2*HALF_W-1:HALF_W];
  assign val  = wr_word[HALF_W-1:0];

  always_ff @(posedge clk) begin
    if (rst)
      q <= '0;
    else if (wr_en)
      q <= (q & ~mask) | (val & mask);
  end

  // R2
  masked_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q ^ $past(q)) & ~$past(mask)) == '0);

  // R2
  enabled_bits_take_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> ((q ^ $past(val)) & $past(mask)) == '0);

  // R3
  unselected_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(q));
endmodule

// File: rtl/wmask_rdata.sv
module wmask_rdata
  import wmask_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                access,
  input  sel_e                sel,
  input  logic [HALF_W-1:0]   ctrl_val,
  input  logic [HALF_W-1:0]   stat_val,
  output logic [2*HALF_W-1:0] rdata,
  output logic                ready
);
  logic [HALF_W-1:0] low_next;

  always_comb begin
    case (sel)
      SEL_CTRL: low_next = ctrl_val;
      SEL_STAT: low_next = stat_val;
      default:  low_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
      ready <= 1'b0;
    end else begin
      ready <= access;
      if (access)
        rdata <= {{HALF_W{1'b0}}, low_next};
    end
  end
endmodule

// File: rtl/wmask_ctrl_bank.sv
module wmask_ctrl_bank
  import wmask_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BASE_ADDR = 16'hF780,
  parameter int NUM_CTRL  = 7,
  parameter int STAT_OFS  = 8'h20,
  parameter int CAL_BIT   = 6,
  parameter int DLL_BIT   = 5
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic                       bus_wr,
  input  logic [WORD_W-1:0]          bus_wdata,
  input  logic                       bus_rd,
  output logic [WORD_W-1:0]          bus_rdata,
  output logic                       bus_ready,
  input  logic                       cal_done_i,
  input  logic                       dll_ready_i,
  output logic [NUM_CTRL*HALF_W-1:0] ctrl_out
);
  localparam int IDX_W = (NUM_CTRL > 1) ? $clog2(NUM_CTRL) : 1;

  sel_e              sel;
  logic [IDX_W-1:0]  idx;
  logic [HALF_W-1:0] regs [NUM_CTRL];
  logic [HALF_W-1:0] ctrl_val;
  logic [HALF_W-1:0] stat_val;
  logic              access;

  assign access = bus_wr | bus_rd;

  wmask_decode #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR), .NUM_CTRL(NUM_CTRL),
    .STAT_OFS(STAT_OFS), .IDX_W(IDX_W)
  ) u_dec (
    .addr(bus_addr), .sel(sel), .idx(idx)
  );

  for (genvar i = 0; i < NUM_CTRL; i++) begin : g_reg
    logic hit;
    assign hit = bus_wr && (sel == SEL_CTRL) && (idx == IDX_W'(i));
    wmask_field #(.HALF_W(HALF_W)) u_field (
      .clk(clk), .rst(rst), .wr_en(hit), .wr_word(bus_wdata), .q(regs[i])
    );
    assign ctrl_out[i*HALF_W +: HALF_W] = regs[i];
  end

  always_comb begin
    ctrl_val = '0;
    for (int i = 0; i < NUM_CTRL; i++)
      if (idx == IDX_W'(i)) ctrl_val = regs[i];
  end

  always_comb begin
    stat_val          = '0;
    stat_val[CAL_BIT] = cal_done_i;
    stat_val[DLL_BIT] = dll_ready_i;
  end

  wmask_rdata #(.HALF_W(HALF_W)) u_rd (
    .clk(clk), .rst(rst), .access(access), .sel(sel),
    .ctrl_val(ctrl_val), .stat_val(stat_val),
    .rdata(bus_rdata), .ready(bus_ready)
  );

  // R7
  ready_after_access_chk: assert property (@(posedge clk) disable iff (rst)
    access |=> bus_ready);

  // R7
  no_spurious_ready_chk: assert property (@(posedge clk) disable iff (rst)
    !access |=> !bus_ready);

  // R5
  upper_half_zero_chk: assert property (@(posedge clk) disable iff (rst)
    bus_ready |-> bus_rdata[WORD_W-1:HALF_W] == '0);

  // R6
  unmapped_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_NONE) |=> bus_rdata == '0);

  // R4
  status_pins_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && sel == SEL_STAT) |=>
      (bus_rdata[CAL_BIT] == $past(cal_done_i) &&
       bus_rdata[DLL_BIT] == $past(dll_ready_i)));

  // R4
  noctrl_write_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (sel != SEL_CTRL) |=> $stable(ctrl_out));
endmodule

// File: tb/wmask_ctrl_bank_test.sv
module wmask_ctrl_bank_test;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CTRL   = 7;
  localparam logic [15:0] BASE = 16'hF780;

  typedef struct {
    bit          chk;
    logic [31:0] val;
    string       tag;
  } item_t;

  logic                     clk = 1'b0;
  logic                     rst = 1'b1;
  logic [15:0]              bus_addr = '0;
  logic                     bus_wr = 1'b0;
  logic [31:0]              bus_wdata = '0;
  logic                     bus_rd = 1'b0;
  logic [31:0]              bus_rdata;
  logic                     bus_ready;
  logic                     cal_done_i = 1'b0;
  logic                     dll_ready_i = 1'b0;
  logic [NUM_CTRL*16-1:0]   ctrl_out;

  int    checks = 0;
  int    errors = 0;
  bit    done = 1'b0;
  item_t sb[$];
  logic [15:0] model [NUM_CTRL];

  always #(CLK_PERIOD/2) clk = ~clk;

  wmask_ctrl_bank uut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .bus_ready(bus_ready), .cal_done_i(cal_done_i),
    .dll_ready_i(dll_ready_i), .ctrl_out(ctrl_out)
  );

  function automatic logic [NUM_CTRL*16-1:0] model_vec();
    logic [NUM_CTRL*16-1:0] v;
    for (int i = 0; i < NUM_CTRL; i++) v[i*16 +: 16] = model[i];
    return v;
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_ctrl(string tag);
    check(tag, 128'(ctrl_out), 128'(model_vec()));
  endtask

  // Monitor: pops one scoreboard entry per ready pulse
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (!rst && bus_ready) begin
        if (sb.size() == 0) begin
          checks++; errors++;
          $display("FAIL R7: actual=ready expected=no ready");
        end else begin
          item_t it;
          it = sb.pop_front();
          checks++;
          if (it.chk && bus_rdata !== it.val) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", it.tag, bus_rdata, it.val);
          end
        end
      end
    end
  end

  // Drive one access at the current negedge; caller releases the bus.
  task automatic issue_write(logic [15:0] a, logic [31:0] d);
    logic [15:0] off;
    item_t it;
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1; bus_rd = 1'b0;
    it.chk = 1'b0; it.val = '0; it.tag = "R7";
    sb.push_back(it);
    off = a - BASE;
    if (off[1:0] == 2'b00 && off < 16'(NUM_CTRL*4))
      model[off[4:2]] = (model[off[4:2]] & ~d[31:16]) | (d[15:0] & d[31:16]);
  endtask

  task automatic issue_read(logic [15:0] a, string tag);
    logic [15:0] off;
    item_t it;
    bus_addr = a; bus_wr = 1'b0; bus_rd = 1'b1;
    off = a - BASE;
    it.chk = 1'b1; it.tag = tag;
    if (off[1:0] == 2'b00 && off < 16'(NUM_CTRL*4))
      it.val = {16'h0, model[off[4:2]]};
    else if (off == 16'h20)
      it.val = {16'h0, 9'h0, cal_done_i, dll_ready_i, 5'h0};
    else
      it.val = '0;
    sb.push_back(it);
  endtask

  task automatic idle();
    bus_wr = 1'b0; bus_rd = 1'b0;
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, string tag);
    @(negedge clk); issue_write(a, d);
    @(negedge clk); idle();
    check_ctrl(tag);
  endtask

  task automatic rd(logic [15:0] a, string tag);
    @(negedge clk); issue_read(a, tag);
    @(negedge clk); idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NUM_CTRL; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check_ctrl("R1");
    check("R1", 128'(bus_ready), 128'(0));
    check("R1", 128'(bus_rdata), 128'(0));

    // R2 / R8 full-mask load, then read back R5
    wr(BASE, 32'hFFFF_A5A5, "R8");
    rd(BASE, "R5");
    // R2 single-bit set: mask bit 20, value bit 4
    wr(BASE, 32'h0010_0010, "R2");
    // R2 mixed: set some, clear some, hold the rest
    wr(BASE, 32'h0F0F_0A05, "R2");
    rd(BASE, "R2");
    // R9 zero mask
    wr(BASE, 32'h0000_FFFF, "R9");
    rd(BASE, "R9");

    // R3 each register distinct, others untouched
    for (int i = 1; i < NUM_CTRL; i++)
      wr(BASE + 16'(4*i), {16'hFFFF, 16'(16'h1111 * i) ^ 16'h8001}, "R3");
    for (int i = 0; i < NUM_CTRL; i++) rd(BASE + 16'(4*i), "R3");
    wr(BASE + 16'd12, 32'h00FF_00AA, "R3");
    rd(BASE + 16'd12, "R3");

    // R4 status inputs
    cal_done_i = 1'b1; dll_ready_i = 1'b0;
    rd(BASE + 16'h20, "R4");
    cal_done_i = 1'b0; dll_ready_i = 1'b1;
    rd(BASE + 16'h20, "R4");
    cal_done_i = 1'b1; dll_ready_i = 1'b1;
    rd(BASE + 16'h20, "R4");
    wr(BASE + 16'h20, 32'hFFFF_FFFF, "R4");

    // R6 unmapped
    rd(BASE + 16'h1C, "R6");
    rd(BASE + 16'h24, "R6");
    rd(BASE + 16'h02, "R6");
    rd(BASE - 16'h04, "R6");
    wr(BASE + 16'h1C, 32'hFFFF_FFFF, "R6");
    wr(BASE + 16'h01, 32'hFFFF_FFFF, "R6");
    wr(BASE - 16'h04, 32'hFFFF_FFFF, "R6");

    // R7 back-to-back reads
    @(negedge clk); issue_read(BASE + 16'd4, "R7");
    @(negedge clk); issue_read(BASE + 16'd8, "R7");
    @(negedge clk); issue_read(BASE + 16'h20, "R7");
    @(negedge clk); idle();
    @(negedge clk);
    @(negedge clk);
    check("R7", 128'(bus_ready), 128'(0));

    // R1 reset mid-run
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    for (int i = 0; i < NUM_CTRL; i++) model[i] = '0;
    @(negedge clk);
    check_ctrl("R1");
    check("R1", 128'(bus_ready), 128'(0));
    rd(BASE + 16'd24, "R1");

    repeat (3) @(negedge clk);
    check("R7", 128'(sb.size()), 128'(0));
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule